// File: doc/BRIEF.md
# Configurable Valid-Ready Register Slice

This block is one pipeline stage placed on a single valid/ready handshake channel. The payload is a generic vector of configurable width. Upstream logic drives the source port. Downstream logic takes transfers from the destination port. The slice passes every transfer through exactly once and in arrival order. It never drops, duplicates or reorders a transfer.

A single parameter, `MODE`, selects one of four architectures. Each has its own cost in timing isolation, storage and throughput:

| `MODE` | Architecture | Behaviour |
|---|---|---|
| 0 | Wire-through | No storage; zero latency. |
| 1 | Two-entry buffer | Registered outputs; runs at full rate. |
| 2 | One-register stage | Leaves an idle cycle after each transfer. |
| 3 | Input-register stage | Captures the source valid and payload in plain flip-flops and still runs back-to-back. |

A channel wrapper can place one instance per channel and give each one the mode that suits the timing and throughput needs of that channel. Typical choices are mode 1 for bulk data channels and mode 2 for address or response channels. Mode 2 is also the usual choice for data channels on a lightweight protocol.

Top module: `hs_slice`

## Requirements
- R1: While `rst` is high, `m_valid` and `s_ready` are low after the first clock edge of reset. Reset clears all held transfers. In modes 1 to 3, `s_ready` stays low in the first cycle after reset is released.
- R2: In mode 0, `m_valid` equals `s_valid`, `m_data` equals `s_data`, and `s_ready` equals `m_ready` in the same cycle, outside reset. With both sides always willing, the slice completes one transfer per cycle.
- R3: In mode 1, a transfer accepted at a clock edge is offered on `m_valid` in the next cycle. With `s_valid` and `m_ready` held high, the slice completes one transfer per cycle with no idle cycles.
- R4: In mode 1, `m_valid` is high whenever at least one transfer is held. `s_ready` is low only while two transfers are held.
- R5: In mode 2, after a transfer is accepted, `s_ready` is low in the next cycle. With both sides always willing, the slice completes one transfer every two cycles.
- R6: In mode 2, `s_ready` is high exactly when the single register is empty. `m_valid` is high exactly when the register is full. After the destination takes the transfer, `s_ready` is high in the next cycle.
- R7: In mode 3, a transfer accepted at a clock edge first appears at the destination in the next cycle. With both sides always willing, the slice completes one transfer per cycle.
- R8: In mode 3, when the destination refuses an offered transfer while `s_ready` is high, `s_ready` goes low in the next cycle. It stays low until the refused transfer has left. No transfer is lost.
- R9: In modes 1 to 3, while `m_valid` is high and `m_ready` is low, the next cycle keeps `m_valid` high with `m_data` unchanged.
- R10: In every mode, transfers leave in the order they were accepted, each exactly once, with the payload unchanged.
- R11: In modes 1 to 3, `m_valid`, `m_data` and `s_ready` change only at clock edges. They do not follow changes on `s_valid`, `s_data` or `m_ready` within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Source offers a transfer |
| s_ready | output | 1 | Slice can accept a transfer |
| s_data | input | WIDTH | Source payload |
| m_valid | output | 1 | Slice offers a transfer to the destination |
| m_ready | input | 1 | Destination takes the offered transfer |
| m_data | output | WIDTH | Destination payload |

## Verification
Suppose a held-transfer flag is wrong, for example a second entry is overwritten or a skid entry is never drained. The damage appears at the destination as a skipped, repeated or out-of-order payload. It is seen on the first cycle that the affected transfer is offered, usually within one or two cycles of the fault. A wrong fullness state shows up instead as `s_ready` or `m_valid` taking the wrong level in the very cycle after the faulty edge. The per-cycle model catches that at once, and the windowed transfer count exposes any lost or extra bubble.

// File: rtl/hs_slice.sv
module hs_slice #(
  parameter int WIDTH = 32,
  parameter int MODE  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [WIDTH-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [WIDTH-1:0] m_data
);

  localparam int PASS = 0;
  localparam int DUAL = 1;
  localparam int SINGLE = 2;
  localparam int INREG = 3;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst && $past(rst) |-> !m_valid && !s_ready);

  generate
    if (MODE == PASS) begin : g_pass
      assign m_valid = s_valid & ~rst;
      assign m_data  = s_data;
      assign s_ready = m_ready & ~rst;

    end else if (MODE == DUAL) begin : g_dual
      logic             up, hd_v, sk_v;
      logic [WIDTH-1:0] hd_d, sk_d;
      logic             take;

      assign take = s_valid & s_ready;

      always_ff @(posedge clk) begin
        if (rst) begin
          up   <= 1'b0;
          hd_v <= 1'b0;
          sk_v <= 1'b0;
        end else begin
          up <= 1'b1;
          if (!hd_v || m_ready) begin
            if (sk_v) begin
              hd_v <= 1'b1;
              hd_d <= sk_d;
              sk_v <= 1'b0;
            end else begin
              hd_v <= take;
              if (take) hd_d <= s_data;
            end
          end else if (take) begin
            sk_v <= 1'b1;
            sk_d <= s_data;
          end
        end
      end

      assign s_ready = up & ~sk_v;
      assign m_valid = hd_v;
      assign m_data  = hd_d;

      assert_next_offer_R3: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready |=> m_valid);
      assert_stall_only_full_R4: assert property (@(posedge clk) disable iff (rst)
        up && !s_ready |-> m_valid);
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data));

    end else if (MODE == SINGLE) begin : g_single
      logic             up, v;
      logic [WIDTH-1:0] d;

      always_ff @(posedge clk) begin
        if (rst) begin
          up <= 1'b0;
          v  <= 1'b0;
        end else begin
          up <= 1'b1;
          if (v) begin
            if (m_ready) v <= 1'b0;
          end else if (s_valid && s_ready) begin
            v <= 1'b1;
            d <= s_data;
          end
        end
      end

      assign s_ready = up & ~v;
      assign m_valid = v;
      assign m_data  = d;

      assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready |=> !s_ready);
      assert_reopen_R6: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_ready |=> s_ready);
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data));

    end else begin : g_inreg
      logic             up, in_v, sk_v;
      logic [WIDTH-1:0] in_d, sk_d;

      always_ff @(posedge clk) begin
        if (rst) begin
          up   <= 1'b0;
          in_v <= 1'b0;
          sk_v <= 1'b0;
        end else begin
          up <= 1'b1;
          if (sk_v) begin
            if (m_ready) sk_v <= 1'b0;
          end else begin
            if (in_v && !m_ready) begin
              sk_v <= 1'b1;
              sk_d <= in_d;
            end
            in_v <= s_valid & s_ready;
            in_d <= s_data;
          end
        end
      end

      assign s_ready = up & ~sk_v;
      assign m_valid = sk_v | in_v;
      assign m_data  = sk_v ? sk_d : in_d;

      assert_next_offer_R7: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready |=> m_valid);
      assert_refuse_closes_R8: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready && s_ready |=> !s_ready);
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data));
    end
  endgenerate

endmodule

// File: tb/hs_slice_test.sv
`timescale 1ns/1ps
module hs_slice_test;
  localparam int W = 16;
  localparam int NCYC = 1600;
  localparam int OPEN0 = 1500;
  localparam int WIN0 = 1510;
  localparam int WINLEN = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g
    logic         sv, sr, mv, mr;
    logic [W-1:0] sd, md;
    int  ncmp = 0;
    int  nbad = 0;
    bit  done = 1'b0;

    hs_slice #(.WIDTH(W), .MODE(m)) uut (
      .clk(clk), .rst(rst),
      .s_valid(sv), .s_ready(sr), .s_data(sd),
      .m_valid(mv), .m_ready(mr), .m_data(md)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
      ncmp++;
      if (!ok) begin
        nbad++;
        $display("FAIL mode %0d %s %s: actual %0h expected %0h", m, tag, what, act, exp);
      end
    endtask

    initial begin
      logic [W-1:0] q[$];
      bit live = 1'b0, skid = 1'b0, pend = 1'b0;
      bit pmv = 1'b0, pmr = 1'b1;
      logic [W-1:0] pmd = '0, omd, e_md;
      bit omv, osr, e_mv, e_sr, acc, outx;
      int seq = 1, thr = 0, exp_thr;
      string tag;
      sv = 1'b0; mr = 1'b0; sd = '0;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
        @(negedge clk);
        #1;
        omv = mv; osr = sr; omd = md;
        if (rst) sv = 1'b0;
        else if (!pend) begin
          if (cyc >= OPEN0)     sv = 1'b1;
          else if (cyc < 750)   sv = ($urandom % 3) != 0;
          else                  sv = ($urandom % 8) != 0;
          sd = W'(seq);
        end
        if (cyc >= OPEN0)      mr = 1'b1;
        else if (cyc < 750)    mr = ($urandom % 2) != 0;
        else                   mr = ($urandom % 4) == 0;
        #1;
        if (m != 0)
          chk(mv == omv && sr == osr && (!mv || md == omd), "R11", "outputs moved with inputs",
              {mv, sr}, {omv, osr});
        case (m)
          0: begin e_sr = !rst && mr;                e_mv = !rst && sv;     tag = "R2"; end
          1: begin e_sr = live && q.size() < 2;      e_mv = q.size() > 0;   tag = "R4"; end
          2: begin e_sr = live && q.size() == 0;     e_mv = q.size() > 0;   tag = "R6"; end
          default: begin e_sr = live && !skid;       e_mv = q.size() > 0;   tag = "R8"; end
        endcase
        if (rst) tag = "R1";
        chk(mv == e_mv, tag, "m_valid", int'(mv), int'(e_mv));
        chk(sr == e_sr, tag, "s_ready", int'(sr), int'(e_sr));
        if (mv && e_mv) begin
          e_md = (m == 0) ? sd : q[0];
          chk(md == e_md, "R10", "payload order", int'(md), int'(e_md));
        end
        if (m != 0 && pmv && !pmr)
          chk(mv && md == pmd, "R9", "stalled output changed", int'(md), int'(pmd));
        acc = sv && sr;
        outx = mv && mr;
        if (cyc >= WIN0 && cyc < WIN0 + WINLEN && acc) thr++;
        if (rst) begin
          q.delete();
          skid = 1'b0;
          live = 1'b0;
        end else begin
          if (m == 3) skid = skid ? !mr : (e_mv && !mr);
          if (m != 0) begin
            if (outx) void'(q.pop_front());
            if (acc) q.push_back(sd);
          end
          live = 1'b1;
        end
        if (acc) seq++;
        pend = sv && !acc;
        pmv = mv; pmr = mr; pmd = md;
      end
      exp_thr = (m == 2) ? WINLEN / 2 : WINLEN;
      case (m)
        0: chk(thr == exp_thr, "R2", "throughput", thr, exp_thr);
        1: chk(thr == exp_thr, "R3", "throughput", thr, exp_thr);
        2: chk(thr == exp_thr, "R5", "throughput", thr, exp_thr);
        default: chk(thr == exp_thr, "R7", "throughput", thr, exp_thr);
      endcase
      done = 1'b1;
    end
  end

  initial begin
    int total, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NCYC + 400; i++) begin
      if (g[0].done && g[1].done && g[2].done && g[3].done) break;
      @(posedge clk);
    end
    total = g[0].ncmp + g[1].ncmp + g[2].ncmp + g[3].ncmp;
    bad   = g[0].nbad + g[1].nbad + g[2].nbad + g[3].nbad;
    if (!(g[0].done && g[1].done && g[2].done && g[3].done)) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual not finished expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule